// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between the core and a 32-bit data memory that is addressed by words. It handles loads and stores of byte, half-word and word size. For a store it takes the two low bits of the effective address, the access size and the source register value. It returns a memory write word and a per-lane byte-enable mask. The data is replicated across lanes so that every enabled lane holds the correct bytes. For a load it takes the word read from memory, the same address bits, the size and an unsigned flag. It picks out the addressed lanes and returns the value sign-extended or zero-extended to 32 bits.

The effective address is formed elsewhere, as the base register plus a sign-extended immediate. Only its low two bits come into this block. Lanes are little-endian: offset 0 is bits 7:0 of the memory word and offset 3 is bits 31:24. An access that is not naturally aligned is flagged. For such an access no byte lane is written and the load result is forced to zero. All outputs are registered, so every result appears one clock after its inputs.

Top module: `lsu_lane_fmt`

## Requirements
- R1: With size code 2'b10 or 2'b11 (word) and offset 0, the load result equals the memory word unchanged.
- R2: With size code 2'b00 (byte), the load result is memory bits [8*offset+7 : 8*offset]. It is sign-extended when the unsigned flag is 0 and zero-extended when the flag is 1.
- R3: With size code 2'b01 (half-word) at offset 0 or 2, the load result is memory bits [8*offset+15 : 8*offset]. It is sign-extended when the unsigned flag is 0 and zero-extended when the flag is 1.
- R4: For aligned accesses the byte-enable mask is as follows. A byte access gives 4'b0001 shifted left by the offset. A half-word access gives 4'b0011 at offset 0 and 4'b1100 at offset 2. A word access gives 4'b1111.
- R5: The write data depends only on the size. A byte access gives the low 8 source bits copied into all four lanes. A half-word access gives the low 16 source bits copied into both halves. A word access gives the source value unchanged.
- R6: A half-word access at offset 1 or 3, or a word access at any nonzero offset, raises the misalign output. It also clears the byte-enable mask to 4'b0000 and forces the load result to zero. A byte access never raises misalign.
- R7: All outputs change exactly one rising clock edge after their inputs. While the active-low reset is held, all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_off | input | 2 | Low two bits of the effective address |
| acc_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| ld_unsigned | input | 1 | 1 selects zero extension on loads |
| st_src | input | 32 | Store source register value |
| mem_rdata | input | 32 | Word read from data memory |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_ben | output | 4 | Per-lane write enables |
| ld_result | output | 32 | Extracted and extended load value |
| misalign | output | 1 | Access not naturally aligned |

## Verification
Every result of this block comes out of a single register stage. The write data, the lane mask, the load value and the misalign flag therefore all become valid on the first rising edge after the inputs are applied. The bench changes inputs on falling edges and compares all four outputs at the next falling edge, half a period after the capturing edge. One directed step instead samples just after new inputs are applied, before any rising edge. There it confirms that the outputs still hold the previous result, which checks that there is exactly one cycle of latency.

// File: rtl/lsu_fmt_pkg.sv
package lsu_fmt_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_fmt_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] off,
    input  acc_size_e        size,
    output logic             misalign
);

    always_comb begin
        case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = off[0];
            default: misalign = |off;
        endcase
    end

endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
    import lsu_fmt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8
) (
    input  logic [$clog2(NUM_LANES)-1:0]  off,
    input  acc_size_e                     size,
    input  logic                          misalign,
    input  logic [NUM_LANES*LANE_W-1:0]   src,
    output logic [NUM_LANES*LANE_W-1:0]   wdata,
    output logic [NUM_LANES-1:0]          ben
);

    localparam logic [NUM_LANES-1:0] ONE_LANE  = NUM_LANES'(1);
    localparam logic [NUM_LANES-1:0] TWO_LANES = NUM_LANES'(3);

    // Each lane picks its slice of the source according to access size
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: wdata[i*LANE_W +: LANE_W] = src[LANE_W-1:0];
                SZ_HALF: wdata[i*LANE_W +: LANE_W] = src[(i%2)*LANE_W +: LANE_W];
                default: wdata[i*LANE_W +: LANE_W] = src[i*LANE_W +: LANE_W];
            endcase
        end
    end

    always_comb begin
        ben = '0;
        if (!misalign) begin
            case (size)
                SZ_BYTE: ben = ONE_LANE << off;
                SZ_HALF: ben = TWO_LANES << off;
                default: ben = '1;
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_fmt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8
) (
    input  logic [NUM_LANES*LANE_W-1:0]   word,
    input  logic [$clog2(NUM_LANES)-1:0]  off,
    input  acc_size_e                     size,
    input  logic                          uns,
    input  logic                          misalign,
    output logic [NUM_LANES*LANE_W-1:0]   result
);

    localparam int DW = NUM_LANES * LANE_W;
    localparam int HW = 2 * LANE_W;

    logic [DW-1:0] shifted;
    logic          sgn_b;
    logic          sgn_h;

    always_comb begin
        shifted = word >> (32'(off) * LANE_W);
        sgn_b   = !uns && shifted[LANE_W-1];
        sgn_h   = !uns && shifted[HW-1];
        if (misalign) begin
            result = '0;
        end else begin
            case (size)
                SZ_BYTE: result = {{(DW-LANE_W){sgn_b}}, shifted[LANE_W-1:0]};
                SZ_HALF: result = {{(DW-HW){sgn_h}}, shifted[HW-1:0]};
                default: result = word;
            endcase
        end
    end

endmodule

// File: rtl/lsu_lane_fmt.sv
module lsu_lane_fmt
    import lsu_fmt_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(NUM_LANES)-1:0]  addr_off,
    input  logic [1:0]                    acc_size,
    input  logic                          ld_unsigned,
    input  logic [NUM_LANES*LANE_W-1:0]   st_src,
    input  logic [NUM_LANES*LANE_W-1:0]   mem_rdata,
    output logic [NUM_LANES*LANE_W-1:0]   mem_wdata,
    output logic [NUM_LANES-1:0]          mem_ben,
    output logic [NUM_LANES*LANE_W-1:0]   ld_result,
    output logic                          misalign
);

    localparam int DW = NUM_LANES * LANE_W;

    typedef struct packed {
        logic [DW-1:0]        wdata;
        logic [NUM_LANES-1:0] ben;
        logic [DW-1:0]        lres;
        logic                 mis;
    } fmt_out_t;

    acc_size_e            size_e;
    logic                 mis_c;
    logic [DW-1:0]        wdata_c;
    logic [NUM_LANES-1:0] ben_c;
    logic [DW-1:0]        lres_c;
    fmt_out_t             out_d;
    fmt_out_t             out_q;

    assign size_e = acc_size_e'(acc_size);

    lsu_align_check #(
        .OFF_W ($clog2(NUM_LANES))
    ) i_align (
        .off      (addr_off),
        .size     (size_e),
        .misalign (mis_c)
    );

    lsu_store_pack #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W)
    ) i_store (
        .off      (addr_off),
        .size     (size_e),
        .misalign (mis_c),
        .src      (st_src),
        .wdata    (wdata_c),
        .ben      (ben_c)
    );

    lsu_load_extract #(
        .NUM_LANES (NUM_LANES),
        .LANE_W    (LANE_W)
    ) i_load (
        .word     (mem_rdata),
        .off      (addr_off),
        .size     (size_e),
        .uns      (ld_unsigned),
        .misalign (mis_c),
        .result   (lres_c)
    );

    always_comb begin
        out_d       = out_q;
        out_d.wdata = wdata_c;
        out_d.ben   = ben_c;
        out_d.lres  = lres_c;
        out_d.mis   = mis_c;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mem_wdata = out_q.wdata;
    assign mem_ben   = out_q.ben;
    assign ld_result = out_q.lres;
    assign misalign  = out_q.mis;

    // R6
    mis_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_ben == '0 && ld_result == '0));

    // R6
    byte_never_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_size) == SZ_BYTE) |-> !misalign);

    // R4
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_size) == SZ_BYTE) |-> $countones(mem_ben) == 1);

    // R1
    word_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_size[1]) && $past(addr_off) == '0)
            |-> ld_result == $past(mem_rdata));

    // R2
    byte_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_size) == SZ_BYTE && !$past(ld_unsigned))
            |-> ld_result[DW-1:LANE_W] == {(DW-LANE_W){ld_result[LANE_W-1]}});

    // R5
    byte_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_size) == SZ_BYTE)
            |-> mem_wdata[2*LANE_W-1:LANE_W] == mem_wdata[LANE_W-1:0]);

endmodule

// File: tb/test_lsu_lane_fmt.sv
module test_lsu_lane_fmt;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  addr_off;
    logic [1:0]  acc_size;
    logic        ld_unsigned;
    logic [31:0] st_src;
    logic [31:0] mem_rdata;
    logic [31:0] mem_wdata;
    logic [3:0]  mem_ben;
    logic [31:0] ld_result;
    logic        misalign;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsu_lane_fmt i_lsu_lane_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_off    (addr_off),
        .acc_size    (acc_size),
        .ld_unsigned (ld_unsigned),
        .st_src      (st_src),
        .mem_rdata   (mem_rdata),
        .mem_wdata   (mem_wdata),
        .mem_ben     (mem_ben),
        .ld_result   (ld_result),
        .misalign    (misalign)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input logic [1:0] off, input logic [1:0] sz,
                         input logic uns, input logic [31:0] src,
                         input logic [31:0] mw,
                         output logic [31:0] wd, output logic [3:0] be,
                         output logic [31:0] lr, output logic mis);
        logic [7:0]  b;
        logic [15:0] h;
        mis = (sz == 2'b01) ? (off == 2'd1 || off == 2'd3)
            : (sz == 2'b00) ? 1'b0 : (off != 2'd0);
        case (sz)
            2'b00:   wd = {src[7:0], src[7:0], src[7:0], src[7:0]};
            2'b01:   wd = {src[15:0], src[15:0]};
            default: wd = src;
        endcase
        if (mis) be = 4'b0000;
        else if (sz == 2'b00) be = 4'b0001 << off;
        else if (sz == 2'b01) be = (off == 2'd0) ? 4'b0011 : 4'b1100;
        else be = 4'b1111;
        case (off)
            2'd0:    b = mw[7:0];
            2'd1:    b = mw[15:8];
            2'd2:    b = mw[23:16];
            default: b = mw[31:24];
        endcase
        h = (off == 2'd2) ? mw[31:16] : mw[15:0];
        if (mis) lr = 32'h0;
        else if (sz == 2'b00) lr = uns ? {24'h0, b} : {{24{b[7]}}, b};
        else if (sz == 2'b01) lr = uns ? {16'h0, h} : {{16{h[15]}}, h};
        else lr = mw;
    endtask

    // drive at negedge, check at next negedge
    task automatic step(input logic [1:0] off, input logic [1:0] sz,
                        input logic uns, input logic [31:0] src,
                        input logic [31:0] mw);
        logic [31:0] wd, lr;
        logic [3:0]  be;
        logic        mis;
        string       lreq;
        addr_off = off; acc_size = sz; ld_unsigned = uns;
        st_src = src; mem_rdata = mw;
        model(off, sz, uns, src, mw, wd, be, lr, mis);
        @(negedge clk);
        lreq = mis ? "R6" : (sz == 2'b00) ? "R2" : (sz == 2'b01) ? "R3" : "R1";
        check("R6", "misalign", {31'h0, misalign}, {31'h0, mis});
        check(mis ? "R6" : "R4", "byte_en", {28'h0, mem_ben}, {28'h0, be});
        check("R5", "wdata", mem_wdata, wd);
        check(lreq, "ld_result", ld_result, lr);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        addr_off = 2'd1; acc_size = 2'b00; ld_unsigned = 1'b0;
        st_src = 32'hDEAD_BEEF; mem_rdata = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R7 reset state
        check("R7", "rst wdata", mem_wdata, 32'h0);
        check("R7", "rst ben", {28'h0, mem_ben}, 32'h0);
        check("R7", "rst ld_result", ld_result, 32'h0);
        check("R7", "rst misalign", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;

        // directed corners: byte lanes, both extensions
        for (int o = 0; o < 4; o++) begin
            step(2'(o), 2'b00, 1'b0, 32'h1234_56A5, 32'h8081_7F80);
            step(2'(o), 2'b00, 1'b1, 32'h1234_56A5, 32'h8081_7F80);
        end
        // half-words all offsets, word all offsets
        for (int o = 0; o < 4; o++) begin
            step(2'(o), 2'b01, 1'b0, 32'hCAFE_8001, 32'h8000_7FFF);
            step(2'(o), 2'b01, 1'b1, 32'hCAFE_8001, 32'h8000_7FFF);
            step(2'(o), 2'b10, 1'b0, 32'hA5A5_0F0F, 32'h89AB_CDEF);
            step(2'(o), 2'b11, 1'b1, 32'hA5A5_0F0F, 32'h89AB_CDEF);
        end

        // R7 latency: new inputs must not show before the next rising edge
        step(2'd0, 2'b10, 1'b0, 32'h1111_1111, 32'h2222_2222);
        addr_off = 2'd3; acc_size = 2'b00; ld_unsigned = 1'b1;
        st_src = 32'h0000_00FF; mem_rdata = 32'h7700_0000;
        #1;
        check("R7", "latency ld_result", ld_result, 32'h2222_2222);
        check("R7", "latency ben", {28'h0, mem_ben}, 32'h0000_000F);
        @(negedge clk);
        check("R7", "after edge ld_result", ld_result, 32'h0000_0077);
        check("R7", "after edge ben", {28'h0, mem_ben}, 32'h0000_0008);

        // constrained random
        for (int k = 0; k < 500; k++) begin
            step(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), $urandom, $urandom);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule